// File: doc/BRIEF.md
# Amplifier Control Register Slave on a Two-Wire Bus

This block is the serial control port of a four-channel car audio amplifier. It watches the two-wire bus lines on a fast system clock. It recognises START and STOP, and it answers only to its own 7-bit device address. A write transfer loads two instruction bytes into control registers. Those registers drive the gain, mute, standby, clip-threshold and diagnostic mode controls of the amplifier.

A read transfer returns four diagnostic bytes, one per channel. Each byte is built at the moment it is sent, from the live per-channel fault flags and a few global status signals. When a read has delivered at least one byte and the master ends it, the block raises a one-cycle strobe. The diagnostic logic uses that strobe to start a fresh measurement cycle.

The system clock must run at least 16 times faster than the bus bit rate. The slave never stretches the clock.

Top module: `amp_ctl_i2c_slave`

## Requirements
- R1: After reset every control output is 0: amplifier in standby, all channels muted, diagnostics, offset detection and line-driver diagnostics off, gains at the high setting, clip threshold low. In the same state `sda_oe` is 0 and `read_done` is 0.
- R2: The address byte is sent MSB first and is 7'b1101100 followed by a R/W bit (0 = write, 1 = read). On a match the slave pulls SDA low during the ninth clock. On a mismatch it never drives SDA and the control outputs do not change until the next START.
- R3: The first written byte sets the following outputs: bit 6 `diag_en`, bit 5 `offs_en`, bit 4 `gain_front`, bit 3 `gain_rear`, bit 2 `unmute_front`, bit 1 `unmute_rear`, bit 0 `clip_sel`. Bit 7 is ignored.
- R4: The second written byte sets the following outputs: bit 5 `fast_mute`, bit 4 `amp_on`, bit 3 `line_diag`. Bits 7, 6 and 2..0 are ignored.
- R5: Written bytes after the second are acknowledged and have no effect. A write that stops after one data byte leaves the second set of controls unchanged.
- R6: A read returns bytes in channel order LF, LR, RF, RR, MSB first. In each byte, bit 3 is short load, bit 2 is output offset, bit 1 is short to supply and bit 0 is short to ground. Flag index 0..3 maps to LF, LR, RF, RR.
- R7: Status bits are placed as follows: byte 0 bit 7 `thermal_warn`, byte 0 bit 6 `diag_done`, byte 1 bit 7 `offset_active`, byte 2 bit 7 `amp_on`, byte 2 bit 6 `diag_en`. Every other bit from 7 down to 4 reads 0.
- R8: `read_done` is a single-cycle pulse, with SDA released. It fires exactly once per read, on the master's NACK or on STOP, whichever comes first, provided at least one byte was sent. Write transfers never produce it.
- R9: The slave changes `sda_oe`, and the control outputs change, only while SCL is low.
- R10: Diagnostic bytes reflect the flag values present when each read takes place. No earlier value is held over from a previous read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| flt_short_load | input | 4 | Short across load per channel (LF, LR, RF, RR = 0..3) |
| flt_offset | input | 4 | Output DC offset detected per channel |
| flt_short_vs | input | 4 | Output shorted to supply per channel |
| flt_short_gnd | input | 4 | Output shorted to ground per channel |
| thermal_warn | input | 1 | Thermal warning status |
| diag_done | input | 1 | Diagnostic cycle has terminated |
| offset_active | input | 1 | Offset detection is running |
| diag_en | output | 1 | Diagnostic enable |
| offs_en | output | 1 | Offset detection enable |
| gain_front | output | 1 | Front gain select, 1 = low gain |
| gain_rear | output | 1 | Rear gain select, 1 = low gain |
| unmute_front | output | 1 | 1 unmutes front channels |
| unmute_rear | output | 1 | 1 unmutes rear channels |
| clip_sel | output | 1 | Clip detector threshold select |
| fast_mute | output | 1 | Fast muting time |
| amp_on | output | 1 | 1 = amplifier working, 0 = standby |
| line_diag | output | 1 | Line-driver diagnostic thresholds |
| read_done | output | 1 | One-cycle pulse at the end of a read |

## Verification
A master NACK on the last byte and the STOP that follows both end a read, so two events compete to produce the same re-arm pulse. The bench ends random-length reads by sending a NACK and then a STOP straight after it. It also ends full four-byte reads by acknowledging the last byte and stopping. In both cases it counts pulses and expects exactly one. Live flags are randomised between transfers, and every returned byte is compared with the value computed from them.

// File: rtl/amp_ctl_i2c_slave.sv
module amp_ctl_i2c_slave #(
  parameter logic [6:0] DEV_ADDR = 7'b1101100,
  parameter int         RD_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [3:0] flt_short_load,
  input  logic [3:0] flt_offset,
  input  logic [3:0] flt_short_vs,
  input  logic [3:0] flt_short_gnd,
  input  logic       thermal_warn,
  input  logic       diag_done,
  input  logic       offset_active,
  output logic       diag_en,
  output logic       offs_en,
  output logic       gain_front,
  output logic       gain_rear,
  output logic       unmute_front,
  output logic       unmute_rear,
  output logic       clip_sel,
  output logic       fast_mute,
  output logic       amp_on,
  output logic       line_diag,
  output logic       read_done
);

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_SKIP} st_t;

  st_t        st;
  logic [2:0] scl_r, sda_r;
  logic [7:0] shreg, txsh, tx_next;
  logic [3:0] bit_cnt;
  logic [2:0] byte_idx;
  logic       is_addr, rw, rd_pend;
  logic [6:0] ib1;
  logic [2:0] ib2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_r <= 3'b111;
      sda_r <= 3'b111;
    end else begin
      scl_r <= {scl_r[1:0], scl_i};
      sda_r <= {sda_r[1:0], sda_i};
    end

  wire sda_q    = sda_r[1];
  wire scl_rise = scl_r[1] & ~scl_r[2];
  wire scl_fall = ~scl_r[1] & scl_r[2];
  wire start_c  = scl_r[1] & scl_r[2] & sda_r[2] & ~sda_r[1];
  wire stop_c   = scl_r[1] & scl_r[2] & ~sda_r[2] & sda_r[1];

  function automatic logic [3:0] nib(input int i);
    return {flt_short_load[i], flt_offset[i], flt_short_vs[i], flt_short_gnd[i]};
  endfunction

  always_comb
    case (byte_idx)
      3'd0:    tx_next = {thermal_warn, diag_done, 2'b00, nib(0)};
      3'd1:    tx_next = {offset_active, 3'b000, nib(1)};
      3'd2:    tx_next = {amp_on, diag_en, 2'b00, nib(2)};
      3'd3:    tx_next = {4'b0000, nib(3)};
      default: tx_next = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= ST_IDLE;
      shreg     <= '0;
      txsh      <= '0;
      bit_cnt   <= '0;
      byte_idx  <= '0;
      is_addr   <= 1'b0;
      rw        <= 1'b0;
      rd_pend   <= 1'b0;
      sda_oe    <= 1'b0;
      read_done <= 1'b0;
      ib1       <= '0;
      ib2       <= '0;
    end else begin
      read_done <= 1'b0;
      if (start_c) begin
        st       <= ST_RX;
        is_addr  <= 1'b1;
        bit_cnt  <= '0;
        byte_idx <= '0;
        sda_oe   <= 1'b0;
        rd_pend  <= 1'b0;
      end else if (stop_c) begin
        st        <= ST_IDLE;
        sda_oe    <= 1'b0;
        read_done <= rd_pend;
        rd_pend   <= 1'b0;
      end else begin
        case (st)
          ST_RX:
            if (scl_rise) begin
              shreg   <= {shreg[6:0], sda_q};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (is_addr) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  rw     <= shreg[0];
                  st     <= ST_RX_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                st     <= ST_RX_ACK;
                if (byte_idx == 3'd0) ib1 <= shreg[6:0];
                else if (byte_idx == 3'd1) ib2 <= shreg[5:3];
                if (byte_idx != 3'd7) byte_idx <= byte_idx + 3'd1;
              end
            end
          ST_RX_ACK:
            if (scl_fall) begin
              is_addr <= 1'b0;
              bit_cnt <= '0;
              if (is_addr && rw) begin
                txsh   <= tx_next;
                sda_oe <= ~tx_next[7];
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
              end
            end
          ST_TX:
            if (scl_fall) begin
              if (bit_cnt == 4'd7) begin
                sda_oe   <= 1'b0;
                st       <= ST_TX_ACK;
                rd_pend  <= 1'b1;
                byte_idx <= byte_idx + 3'd1;
                bit_cnt  <= '0;
              end else begin
                txsh    <= {txsh[6:0], 1'b0};
                sda_oe  <= ~txsh[6];
                bit_cnt <= bit_cnt + 4'd1;
              end
            end
          ST_TX_ACK:
            if (scl_rise) begin
              if (sda_q) begin
                read_done <= rd_pend;
                rd_pend   <= 1'b0;
                st        <= ST_SKIP;
              end
            end else if (scl_fall) begin
              if (byte_idx < 3'(RD_BYTES)) begin
                txsh   <= tx_next;
                sda_oe <= ~tx_next[7];
                st     <= ST_TX;
              end else begin
                st <= ST_SKIP;
              end
            end
          default: ;
        endcase
      end
    end

  assign diag_en      = ib1[6];
  assign offs_en      = ib1[5];
  assign gain_front   = ib1[4];
  assign gain_rear    = ib1[3];
  assign unmute_front = ib1[2];
  assign unmute_rear  = ib1[1];
  assign clip_sel     = ib1[0];
  assign fast_mute    = ib2[2];
  assign amp_on       = ib2[1];
  assign line_diag    = ib2[0];

endmodule

// File: rtl/amp_ctl_i2c_chk.sv
module amp_ctl_i2c_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       read_done,
  input logic [9:0] ctrl
);

  // R8
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_done |=> !read_done);

  // R8
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    read_done |-> !sda_oe);

  // R9
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  // R9
  ctrl_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl != $past(ctrl)) |-> !scl_i);

endmodule

bind amp_ctl_i2c_slave amp_ctl_i2c_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .read_done(read_done),
  .ctrl({diag_en, offs_en, gain_front, gain_rear, unmute_front, unmute_rear,
         clip_sel, fast_mute, amp_on, line_diag})
);

// File: tb/amp_ctl_i2c_slave_tb.sv
module amp_ctl_i2c_slave_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [3:0] f_ld = '0, f_of = '0, f_vs = '0, f_gn = '0;
  logic t_warn = 1'b0, d_done = 1'b0, o_act = 1'b0;
  logic sda_oe, read_done;
  logic diag_en, offs_en, gain_front, gain_rear, unmute_front, unmute_rear, clip_sel;
  logic fast_mute, amp_on, line_diag;
  wire  sda_bus = m_sda & ~sda_oe;

  int checks = 0, fails = 0, pulses = 0;
  logic [6:0] m_ib1 = '0;
  logic [2:0] m_ib2 = '0;

  always #2.5 clk = ~clk;

  amp_ctl_i2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .flt_short_load(f_ld), .flt_offset(f_of), .flt_short_vs(f_vs), .flt_short_gnd(f_gn),
    .thermal_warn(t_warn), .diag_done(d_done), .offset_active(o_act),
    .diag_en(diag_en), .offs_en(offs_en), .gain_front(gain_front), .gain_rear(gain_rear),
    .unmute_front(unmute_front), .unmute_rear(unmute_rear), .clip_sel(clip_sel),
    .fast_mute(fast_mute), .amp_on(amp_on), .line_diag(line_diag), .read_done(read_done)
  );

  always @(posedge clk) if (read_done) pulses <= pulses + 1;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(); repeat (Q) @(negedge clk); endtask
  task automatic i2c_start(); m_sda = 1; w(); m_scl = 1; w(); m_sda = 0; w(); m_scl = 0; w(); endtask
  task automatic i2c_stop();  m_sda = 0; w(); m_scl = 1; w(); m_sda = 1; w(); endtask
  task automatic put_bit(input logic b); m_sda = b; w(); m_scl = 1; w(); w(); m_scl = 0; w(); endtask
  task automatic get_bit(output logic b); m_sda = 1; w(); m_scl = 1; w(); b = sda_bus; w(); m_scl = 0; w(); endtask

  task automatic wr_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a);
    ack = !a;
  endtask

  task automatic rd_byte(output logic [7:0] d, input logic ack);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(!ack);
  endtask

  function automatic logic [9:0] ctrl_now();
    return {diag_en, offs_en, gain_front, gain_rear, unmute_front, unmute_rear, clip_sel,
            fast_mute, amp_on, line_diag};
  endfunction

  function automatic logic [7:0] exp_byte(input int k);
    logic [3:0] n = {f_ld[k], f_of[k], f_vs[k], f_gn[k]};
    case (k)
      0: return {t_warn, d_done, 2'b00, n};
      1: return {o_act, 3'b000, n};
      2: return {m_ib2[1], m_ib1[6], 2'b00, n};
      default: return {4'b0000, n};
    endcase
  endfunction

  task automatic do_write(input logic [7:0] b1, input logic [7:0] b2, input int nb);
    logic ack;
    i2c_start();
    wr_byte(8'hD8, ack); chk(ack, "R2 write addr ack", ack, 1);
    if (nb > 0) begin wr_byte(b1, ack); chk(ack, "R3 byte1 ack", ack, 1); m_ib1 = b1[6:0]; end
    if (nb > 1) begin wr_byte(b2, ack); chk(ack, "R4 byte2 ack", ack, 1); m_ib2 = b2[5:3]; end
    for (int i = 2; i < nb; i++) begin
      wr_byte(8'($urandom), ack); chk(ack, "R5 extra byte ack", ack, 1);
    end
    i2c_stop();
    w();
    chk(ctrl_now() == {m_ib1, m_ib2}, "R3 R4 R5 control outputs", ctrl_now(), {m_ib1, m_ib2});
  endtask

  task automatic do_read(input int nb, input logic last_ack);
    logic ack;
    logic [7:0] d;
    int p0 = pulses;
    i2c_start();
    wr_byte(8'hD9, ack); chk(ack, "R2 read addr ack", ack, 1);
    for (int k = 0; k < nb; k++) begin
      rd_byte(d, (k == nb - 1) ? last_ack : 1'b1);
      chk(d == exp_byte(k), "R6 R7 R10 diag byte", d, exp_byte(k));
    end
    i2c_stop();
    w();
    chk(pulses == p0 + 1, "R8 one pulse per read", pulses - p0, 1);
  endtask

  task automatic rand_flags();
    f_ld = 4'($urandom); f_of = 4'($urandom); f_vs = 4'($urandom); f_gn = 4'($urandom);
    t_warn = 1'($urandom); d_done = 1'($urandom); o_act = 1'($urandom);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    int p0;
    void'($urandom(32'd7562));
    repeat (5) @(negedge clk);
    rst_n = 1;
    w();
    // R1
    chk(ctrl_now() == 10'd0, "R1 reset controls", ctrl_now(), 0);
    chk(!sda_oe && pulses == 0, "R1 reset sda/strobe", {sda_oe, pulses[0]}, 0);

    // R2 mismatch: no ack, controls unchanged
    i2c_start();
    wr_byte(8'hDA, ack); chk(!ack, "R2 wrong address no ack", ack, 0);
    wr_byte(8'h7F, ack); chk(!ack, "R2 ignored data no ack", ack, 0);
    i2c_stop(); w();
    chk(ctrl_now() == 10'd0, "R2 mismatch leaves controls", ctrl_now(), 0);

    // R5 single-byte write, then extra bytes discarded
    do_write(8'hFF, 8'h00, 1);
    do_write(8'h80, 8'hC7, 2);
    p0 = pulses;
    do_write(8'h55, 8'hFF, 5);
    chk(pulses == p0, "R8 no pulse on write", pulses - p0, 0);

    // R8 full read acked then STOP; NACK then STOP
    rand_flags(); do_read(4, 1'b1);
    rand_flags(); do_read(1, 1'b0);

    for (int it = 0; it < 16; it++) begin
      do_write(8'($urandom), 8'($urandom), 1 + ($urandom % 3));
      rand_flags();
      begin
        int n = 1 + ($urandom % 4);
        do_read(n, (n == 4) ? 1'($urandom) : 1'b0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule